// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the slave end of a three-wire control bus made of an enable line, a serial clock and one bidirectional data line. A host frames each transaction by holding the enable high. It first clocks in an eight-bit header, least significant bit first. The top header bit chooses between a write and a read. The low six bits pick one of the byte-wide configuration registers that the block keeps. The analog circuits elsewhere on the chip take those registers in parallel through a flat output vector.

A write puts the new value into the register only when the enable line drops. The value is the last eight bits seen after the header, so short writes are thrown away and long writes keep their final byte. A read copies the selected register as soon as the header completes. After two idle clocks, the block drives the bits out on falling serial-clock edges, with a separate output enable that the pad logic uses to turn the line around. All three bus lines are synchronised into a faster system clock, and all edge decisions are made in that clock.

Top module: `serreg_slave`

## Requirements
- R1: After reset every register reads as zero, except the identity register at index 15, which holds 8'h03. The output enable is low.
- R2: While the enable line is high, header bits are sampled on rising serial-clock edges, least significant first. Bits 5..0 select the register index, bit 6 has no effect, and bit 7 = 0 makes the transaction a write.
- R3: In a write, the falling edge of the enable line copies the byte that followed the header (first bit = bit 0) into the selected register. Register i appears on regs_o[8*i+7:8*i].
- R4: If more than eight bits follow the header, only the last eight bits received before the enable falls are stored, and the header stays the first eight bits.
- R5: A write that ends with fewer than sixteen bits in total changes no register.
- R6: A transaction that ends before the eighth header bit changes nothing, and the next transaction is decoded normally.
- R7: A read (header bit 7 = 1) captures the register on the eighth rising edge. Two more rising edges pass with the output enable low. Each of the next eight falling edges drives bit 0 through bit 7 with the output enable high. The following falling edge releases the output enable.
- R8: When the enable input is low, the output enable is low in the same cycle. A read that is cut short stops driving at once.
- R9: The identity register at index 15 is read-only, and a write addressed to it leaves it at 8'h03.
- R10: Indices 16 to 63 hold no register. A write to one of them changes nothing, and a read from one of them shifts out zeros.
- R11: With the enable input held low, activity on the clock and data lines changes no register and never enables the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sen_i | input | 1 | Serial enable; a transaction is framed while high |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data from the host |
| sdata_o | output | 1 | Serial data towards the host during read-out |
| sdata_oe | output | 1 | Drive enable for the data pad |
| regs_o | output | 128 | All registers, index i at bits 8*i+7 to 8*i |

## Verification
Writes are sent at exactly sixteen bits, with twelve data bits, and cut short both during the header and during the data byte. Comparing these shows that the block stores the trailing byte and throws away incomplete frames. Header patterns with bit 6 set, indices past the register file, and the read-only identity index show that the index is decoded from six bits, that the spare bit has no effect, and that writes go nowhere outside the writable range. Reads are sampled after every falling edge, which checks the wait cycles, the bit order and the release of the output enable. An aborted read and a long burst with the enable held low check that driving stops at once and that a dead enable line is harmless.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

  localparam int HDR_BITS  = 8;
  localparam int BYTE_BITS = 8;
  localparam int WAIT_RISE = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PROG,
    ST_RWAIT,
    ST_RSHIFT
  } xfer_state_t;

endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sen_i,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic sen_s,
  output logic sen_fall,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sdata_s
);

  logic [STAGES-1:0] sen_p, sclk_p, sd_p;
  logic [STAGES-1:0] sen_p_n, sclk_p_n, sd_p_n;
  logic              sen_q, sclk_q;

  // Shift chains, next value computed separately from the registers.
  always_comb begin
    sen_p_n  = {sen_p[STAGES-2:0],  sen_i};
    sclk_p_n = {sclk_p[STAGES-2:0], sclk_i};
    sd_p_n   = {sd_p[STAGES-2:0],   sdata_i};
  end

  // Reset values model the safe idle levels: enable low, clock low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sen_p  <= '0;
      sclk_p <= '0;
      sd_p   <= '0;
      sen_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      sen_p  <= sen_p_n;
      sclk_p <= sclk_p_n;
      sd_p   <= sd_p_n;
      sen_q  <= sen_p[STAGES-1];
      sclk_q <= sclk_p[STAGES-1];
    end
  end

  assign sen_s     = sen_p[STAGES-1];
  assign sdata_s   = sd_p[STAGES-1];
  assign sen_fall  = sen_q & ~sen_p[STAGES-1];
  assign sclk_rise = ~sclk_q & sclk_p[STAGES-1];
  assign sclk_fall = sclk_q & ~sclk_p[STAGES-1];

endmodule

// File: rtl/serreg_ctrl.sv
module serreg_ctrl
  import serreg_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sen_s,
  input  logic                 sen_fall,
  input  logic                 sclk_rise,
  input  logic                 sclk_fall,
  input  logic                 sdata_s,
  input  logic [BYTE_BITS-1:0] rd_data,
  output logic [AW-1:0]        rd_addr,
  output logic                 wr_en,
  output logic [AW-1:0]        wr_addr,
  output logic [BYTE_BITS-1:0] wr_data,
  output logic                 sdo,
  output logic                 oe_q
);

  localparam int CW = $clog2(BYTE_BITS + 1);

  xfer_state_t          state_q, state_n;
  logic [HDR_BITS-1:0]  hdr_q, hdr_n, hdr_shift;
  logic [CW-1:0]        hcnt_q, hcnt_n;
  logic [BYTE_BITS-1:0] dat_q, dat_n;
  logic [CW-1:0]        dcnt_q, dcnt_n;
  logic [1:0]           wcnt_q, wcnt_n;
  logic [BYTE_BITS-1:0] rsh_q, rsh_n;
  logic [CW-1:0]        ocnt_q, ocnt_n;
  logic                 sdo_q, sdo_n;
  logic                 oe_n;

  assign hdr_shift = {sdata_s, hdr_q[HDR_BITS-1:1]};
  assign rd_addr   = hdr_shift[AW-1:0];
  assign wr_addr   = hdr_q[AW-1:0];
  assign wr_data   = dat_q;
  assign sdo       = sdo_q;

  always_comb begin
    state_n = state_q;
    hdr_n   = hdr_q;
    hcnt_n  = hcnt_q;
    dat_n   = dat_q;
    dcnt_n  = dcnt_q;
    wcnt_n  = wcnt_q;
    rsh_n   = rsh_q;
    ocnt_n  = ocnt_q;
    sdo_n   = sdo_q;
    oe_n    = oe_q;
    wr_en   = 1'b0;
    if (!sen_s) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
      if (sen_fall && state_q == ST_PROG && dcnt_q == CW'(BYTE_BITS))
        wr_en = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_n = ST_HDR;
          hcnt_n  = '0;
          dcnt_n  = '0;
          wcnt_n  = '0;
          ocnt_n  = '0;
        end
        ST_HDR: begin
          if (sclk_rise) begin
            hdr_n  = hdr_shift;
            hcnt_n = hcnt_q + 1'b1;
            if (hcnt_q == CW'(HDR_BITS - 1)) begin
              if (sdata_s) begin
                rsh_n   = rd_data;
                state_n = ST_RWAIT;
              end else begin
                state_n = ST_PROG;
              end
            end
          end
        end
        ST_PROG: begin
          if (sclk_rise) begin
            dat_n = {sdata_s, dat_q[BYTE_BITS-1:1]};
            if (dcnt_q != CW'(BYTE_BITS))
              dcnt_n = dcnt_q + 1'b1;
          end
        end
        ST_RWAIT: begin
          if (sclk_rise) begin
            if (wcnt_q == 2'(WAIT_RISE - 1))
              state_n = ST_RSHIFT;
            else
              wcnt_n = wcnt_q + 1'b1;
          end
        end
        ST_RSHIFT: begin
          if (sclk_fall) begin
            if (ocnt_q != CW'(BYTE_BITS)) begin
              sdo_n  = rsh_q[0];
              rsh_n  = {1'b0, rsh_q[BYTE_BITS-1:1]};
              oe_n   = 1'b1;
              ocnt_n = ocnt_q + 1'b1;
            end else begin
              oe_n = 1'b0;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      hcnt_q  <= '0;
      dat_q   <= '0;
      dcnt_q  <= '0;
      wcnt_q  <= '0;
      rsh_q   <= '0;
      ocnt_q  <= '0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      hdr_q   <= hdr_n;
      hcnt_q  <= hcnt_n;
      dat_q   <= dat_n;
      dcnt_q  <= dcnt_n;
      wcnt_q  <= wcnt_n;
      rsh_q   <= rsh_n;
      ocnt_q  <= ocnt_n;
      sdo_q   <= sdo_n;
      oe_q    <= oe_n;
    end
  end

  AST_COMMIT_AFTER_SEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !sen_s); // R3
  AST_SEN_DROP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sen_s) |=> !oe_q); // R8
  AST_QUIET_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RWAIT) |-> !oe_q); // R7
  AST_OUT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ocnt_q <= CW'(BYTE_BITS)); // R7

endmodule

// File: rtl/serreg_bank.sv
module serreg_bank
  import serreg_pkg::*;
#(
  parameter int                 NUM_REGS = 16,
  parameter int                 AW       = 6,
  parameter int                 ID_IDX   = 15,
  parameter logic [BYTE_BITS-1:0] ID_VAL = 8'h03
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [BYTE_BITS-1:0]          wr_data,
  input  logic [AW-1:0]                 rd_addr,
  output logic [BYTE_BITS-1:0]          rd_data,
  output logic [NUM_REGS*BYTE_BITS-1:0] regs_o
);

  localparam int IDXW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [BYTE_BITS-1:0] view [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == ID_IDX) begin : g_id
      assign view[i] = ID_VAL;
    end else begin : g_rw
      logic                 hit;
      logic [BYTE_BITS-1:0] store_q, store_n;
      assign hit = wr_en && (wr_addr == AW'(i));
      always_comb begin
        store_n = store_q;
        if (hit)
          store_n = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store_q <= '0;
        else        store_q <= store_n;
      end
      assign view[i] = store_q;

      AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (store_q == $past(wr_data))); // R3
    end
    assign regs_o[i*BYTE_BITS +: BYTE_BITS] = view[i];
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < NUM_REGS)
      rd_data = view[rd_addr[IDXW-1:0]];
  end

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o)); // R5

endmodule

// File: rtl/serreg_slave.sv
module serreg_slave
  import serreg_pkg::*;
#(
  parameter int                   NUM_REGS    = 16,
  parameter int                   AW          = 6,
  parameter int                   ID_IDX      = 15,
  parameter logic [BYTE_BITS-1:0] ID_VAL      = 8'h03,
  parameter int                   SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sen_i,
  input  logic                          sclk_i,
  input  logic                          sdata_i,
  output logic                          sdata_o,
  output logic                          sdata_oe,
  output logic [NUM_REGS*BYTE_BITS-1:0] regs_o
);

  logic [1:0]           rst_pipe;
  logic                 rst_core_n;
  logic                 sen_s, sen_fall, sclk_rise, sclk_fall, sdata_s;
  logic                 wr_en, oe_q;
  logic [AW-1:0]        wr_addr, rd_addr;
  logic [BYTE_BITS-1:0] wr_data, rd_data;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  serreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sen_i     (sen_i),
    .sclk_i    (sclk_i),
    .sdata_i   (sdata_i),
    .sen_s     (sen_s),
    .sen_fall  (sen_fall),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdata_s   (sdata_s)
  );

  serreg_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sen_s     (sen_s),
    .sen_fall  (sen_fall),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdata_s   (sdata_s),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sdo       (sdata_o),
    .oe_q      (oe_q)
  );

  serreg_bank #(
    .NUM_REGS (NUM_REGS),
    .AW       (AW),
    .ID_IDX   (ID_IDX),
    .ID_VAL   (ID_VAL)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .regs_o  (regs_o)
  );

  // The raw enable gates the pad so an abort needs no synchroniser delay.
  assign sdata_oe = oe_q & sen_i;

endmodule

// File: tb/serreg_slave_bench.sv
`timescale 1ns/1ps
module serreg_slave_bench;

  localparam int NREG = 16;
  localparam int HP   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sen = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic            sdo, soe;
  logic [NREG*8-1:0] regs;
  int              n_chk = 0, n_fail = 0;
  bit              done = 1'b0;

  always #4 clk = ~clk;

  serreg_slave u_serreg_slave (
    .clk(clk), .rst_n(rst_n), .sen_i(sen), .sclk_i(sclk), .sdata_i(sdi),
    .sdata_o(sdo), .sdata_oe(soe), .regs_o(regs)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rv(input int i);
    return regs[i*8 +: 8];
  endfunction

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sdi = v[i];
      wclk(HP); sclk = 1'b1;
      wclk(HP); sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] v, input int n);
    sen = 1'b1; wclk(HP);
    send_bits(v, n);
    wclk(HP); sen = 1'b0; wclk(12);
  endtask

  task automatic do_read(input logic [5:0] idx, input string req, output logic [7:0] got);
    got = '0;
    sen = 1'b1; wclk(HP);
    send_bits({24'd0, 2'b10, idx}, 8);
    for (int p = 9; p <= 18; p++) begin
      wclk(HP); sclk = 1'b1;
      wclk(HP); sclk = 1'b0;
      wclk(HP - 1);
      if (p == 9 || p == 18) chk({req, " R7 oe idle"}, 32'(soe), 32'd0);
      else begin
        chk({req, " R7 oe bit"}, 32'(soe), 32'd1);
        got[p-10] = sdo;
      end
    end
    wclk(1); sen = 1'b0; wclk(12);
  endtask

  task automatic t_reset;
    for (int i = 0; i < NREG; i++) chk("R1 reset value", 32'(rv(i)), (i == 15) ? 32'h03 : 32'h0);
    chk("R1 oe at reset", 32'(soe), 32'd0);
  endtask

  task automatic t_write;
    frame({16'd0, 8'hA5, 8'h03}, 16);
    chk("R3 write idx3", 32'(rv(3)), 32'hA5);
    chk("R3 neighbour", 32'(rv(2)), 32'h0);
  endtask

  task automatic t_a6;
    frame({16'd0, 8'h3C, 8'h45}, 16);
    chk("R2 bit6 ignored", 32'(rv(5)), 32'h3C);
  endtask

  task automatic t_long;
    frame({12'd0, 12'hABC, 8'h04}, 20);
    chk("R4 last byte kept", 32'(rv(4)), 32'hAB);
  endtask

  task automatic t_short;
    logic [NREG*8-1:0] snap;
    snap = regs;
    frame({16'd0, 8'hFF, 8'h03}, 13);
    chk("R5 short write", 32'(rv(3)), 32'hA5);
    chk("R5 all unchanged", 32'(regs == snap), 32'd1);
    frame({27'd0, 5'h06}, 5);
    chk("R6 short header", 32'(regs == snap), 32'd1);
    frame({16'd0, 8'h11, 8'h06}, 16);
    chk("R6 next frame decoded", 32'(rv(6)), 32'h11);
  endtask

  task automatic t_read;
    logic [7:0] g;
    do_read(6'd3, "idx3", g);
    chk("R7 read idx3", 32'(g), 32'hA5);
    do_read(6'd4, "idx4", g);
    chk("R7 read idx4", 32'(g), 32'hAB);
  endtask

  task automatic t_id;
    logic [7:0] g;
    do_read(6'd15, "id", g);
    chk("R9 id read", 32'(g), 32'h03);
    frame({16'd0, 8'hFF, 8'h0F}, 16);
    chk("R9 id after write", 32'(rv(15)), 32'h03);
    do_read(6'd15, "id2", g);
    chk("R9 id read again", 32'(g), 32'h03);
  endtask

  task automatic t_range;
    logic [NREG*8-1:0] snap;
    logic [7:0] g;
    snap = regs;
    frame({16'd0, 8'h77, 8'h14}, 16);
    chk("R10 write idx20", 32'(regs == snap), 32'd1);
    do_read(6'd20, "idx20", g);
    chk("R10 read idx20", 32'(g), 32'h00);
  endtask

  task automatic t_abort;
    sen = 1'b1; wclk(HP);
    send_bits({24'd0, 8'h83}, 8);
    for (int p = 9; p <= 12; p++) begin
      wclk(HP); sclk = 1'b1;
      wclk(HP); sclk = 1'b0;
    end
    wclk(HP);
    chk("R8 driving before abort", 32'(soe), 32'd1);
    sen = 1'b0; #1;
    chk("R8 oe drops at once", 32'(soe), 32'd0);
    wclk(12);
    chk("R8 oe stays low", 32'(soe), 32'd0);
  endtask

  task automatic t_stuck;
    logic [NREG*8-1:0] snap;
    int hits;
    snap = regs;
    hits = 0;
    sen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      sdi = i[0] ^ i[2];
      wclk(HP); sclk = 1'b1;
      if (soe) hits++;
      wclk(HP); sclk = 1'b0;
      if (soe) hits++;
    end
    wclk(12);
    chk("R11 no change with enable low", 32'(regs == snap), 32'd1);
    chk("R11 never driven", 32'(hits), 32'd0);
  endtask

  initial begin
    wclk(5); rst_n = 1'b1; wclk(5);
    t_reset;
    t_write;
    t_a6;
    t_long;
    t_short;
    t_read;
    t_id;
    t_range;
    t_abort;
    t_stuck;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule